// File: doc/BRIEF.md
# Sprite Attribute Page Copy Engine

This block copies one fixed-size block of bytes from the system address space into the sprite attribute memory. A single CPU write to its trigger register starts the copy: the written byte names a 256-byte-aligned source page, and the engine walks that page from offset zero, one byte per step. In each step it reads one byte through a system bus master port, waits for the read to be returned, and then writes that byte into the attribute memory at the matching offset.

The trigger register keeps the last byte written, and the CPU can read it back. A busy flag covers the whole copy, and a one-cycle done pulse marks its end. A new trigger that arrives during a copy abandons the old copy and starts over from offset zero with the new page. The copy length, the attribute base address and the register address are parameters. Their defaults are a 160-byte copy, a zero base and register address 6.

Top module: `sprite_page_dma`

## Requirements
- R1: A CPU write with `cpu_wr`=1 and `cpu_addr`=TRIG_ADDR (default 6) stores `cpu_wdata` in the trigger register. `cpu_rdata` shows that value combinationally whenever `cpu_addr`=TRIG_ADDR and shows 0 at every other address.
- R2: The source address of step k is page*256 + k, which is {page byte, k[7:0]} on `rd_addr`. The first read of a copy uses offset 0.
- R3: Each trigger that is not interrupted produces exactly COUNT (default 160) attribute writes.
- R4: The attribute write of step k goes to OAM_BASE + k (default base 0), so the destination advances in step with the source offset.
- R5: `oam_wdata` of step k equals the `rd_data` that was accepted for step k.
- R6: `rd_req` stays high until a cycle with `rd_valid`=1. The write for that byte is issued in the next cycle, and each step produces exactly one write. `rd_valid` has no effect while `rd_req` is low.
- R7: `busy` is 1 in the cycle after a trigger write. It falls in the cycle after the last write. In that same cycle `done` is 1, for exactly one cycle.
- R8: A trigger write during a copy, including one in the cycle of the final write, restarts the copy at offset 0 with the new page. The abandoned copy produces no `done`.
- R9: Synchronous active-high `rst` clears `busy`, `done`, the offset counter and the trigger register. No write follows until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | REG_AW | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | DATA_W | CPU write data (source page byte) |
| cpu_rdata | output | DATA_W | CPU read data |
| rd_req | output | 1 | System bus read request |
| rd_addr | output | SYS_AW | System bus read address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DATA_W | Read data |
| oam_we | output | 1 | Attribute memory write enable |
| oam_addr | output | OAM_AW | Attribute memory write address |
| oam_wdata | output | DATA_W | Attribute memory write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |

## Verification
The hardest case to reach is a new trigger that lands in the same cycle as the 160th write. In that cycle the restart must win over completion, so no done pulse may appear. The bench counts the writes it observes and, in the middle of the cycle in which it sees the last write, raises the trigger so that the same clock edge receives both. Other runs sweep several pages with read latencies of zero to several cycles, retrigger part-way through a copy, and reset during a copy.

// File: rtl/spd_pkg.sv
package spd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } spd_state_t;
endpackage

// File: rtl/spd_trig_reg.sv
module spd_trig_reg #(
   parameter int REG_AW    = 4,
   parameter int DATA_W    = 8,
   parameter int TRIG_ADDR = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [REG_AW-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [DATA_W-1:0] page_q,
   output logic              trig
);
   localparam logic [REG_AW-1:0] SEL = REG_AW'(TRIG_ADDR);

   logic hit;
   assign hit  = (cpu_addr == SEL);
   assign trig = cpu_wr && hit;

   always_ff @(posedge clk) begin
      if (rst)       page_q <= '0;
      else if (trig) page_q <= cpu_wdata;
   end

   assign cpu_rdata = hit ? page_q : '0;
endmodule

// File: rtl/spd_addr_gen.sv
module spd_addr_gen #(
   parameter int SYS_AW   = 16,
   parameter int PAGE_W   = 8,
   parameter int OAM_AW   = 8,
   parameter int OAM_BASE = 0,
   parameter int COUNT    = 160
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clear,
   input  logic                     step,
   input  logic [SYS_AW-PAGE_W-1:0] page,
   output logic [SYS_AW-1:0]        src_addr,
   output logic [OAM_AW-1:0]        dst_addr,
   output logic                     last
);
   localparam logic [PAGE_W-1:0] LAST_OFF = PAGE_W'(COUNT - 1);

   logic [PAGE_W-1:0] offset;

   always_ff @(posedge clk) begin
      if (rst || clear) offset <= '0;
      else if (step)    offset <= offset + 1'b1;
   end

   assign last     = (offset == LAST_OFF);
   assign src_addr = {page, offset};

   generate
      if (OAM_BASE == 0) begin : g_dst_direct
         if (OAM_AW > PAGE_W) begin : g_ext
            assign dst_addr = {{(OAM_AW-PAGE_W){1'b0}}, offset};
         end else begin : g_trunc
            assign dst_addr = offset[OAM_AW-1:0];
         end
      end else begin : g_dst_offset
         assign dst_addr = OAM_AW'(OAM_BASE) + OAM_AW'(offset);
      end
   endgenerate
endmodule

// File: rtl/spd_seq.sv
module spd_seq
   import spd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trig,
   input  logic              last,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic              oam_we,
   output logic [DATA_W-1:0] oam_wdata,
   output logic              step,
   output logic              busy,
   output logic              done
);
   spd_state_t        state;
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         done  <= 1'b0;
         hold  <= '0;
      end else begin
         done <= 1'b0;
         if (trig) begin
            state <= ST_READ;
         end else begin
            case (state)
               ST_READ: if (rd_valid) begin
                  hold  <= rd_data;
                  state <= ST_WRITE;
               end
               ST_WRITE: if (last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_READ;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign rd_req    = (state == ST_READ);
   assign oam_we    = (state == ST_WRITE);
   assign oam_wdata = hold;
   assign step      = (state == ST_WRITE) && !last;
   assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma #(
   parameter int REG_AW    = 4,
   parameter int TRIG_ADDR = 6,
   parameter int DATA_W    = 8,
   parameter int SYS_AW    = 16,
   parameter int PAGE_W    = 8,
   parameter int OAM_AW    = 8,
   parameter int OAM_BASE  = 0,
   parameter int COUNT     = 160
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [REG_AW-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              rd_req,
   output logic [SYS_AW-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              oam_we,
   output logic [OAM_AW-1:0] oam_addr,
   output logic [DATA_W-1:0] oam_wdata,
   output logic              busy,
   output logic              done
);
   localparam int PAGE_BITS = SYS_AW - PAGE_W;

   generate
      if (PAGE_BITS != DATA_W) begin : g_bad_page
         $error("SYS_AW - PAGE_W must equal DATA_W");
      end
      if (COUNT < 1 || COUNT > (1 << PAGE_W)) begin : g_bad_count
         $error("COUNT must lie in 1 .. 2**PAGE_W");
      end
      if (OAM_BASE + COUNT > (1 << OAM_AW)) begin : g_bad_oam
         $error("copy does not fit the attribute memory");
      end
      if (TRIG_ADDR >= (1 << REG_AW)) begin : g_bad_reg
         $error("TRIG_ADDR outside register space");
      end
   endgenerate

   logic [DATA_W-1:0] page_q;
   logic              trig_w;
   logic              last_w;
   logic              step_w;

   spd_trig_reg #(.REG_AW(REG_AW), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR)) u_reg (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .page_q(page_q), .trig(trig_w)
   );

   spd_addr_gen #(.SYS_AW(SYS_AW), .PAGE_W(PAGE_W), .OAM_AW(OAM_AW),
                  .OAM_BASE(OAM_BASE), .COUNT(COUNT)) u_addr (
      .clk(clk), .rst(rst), .clear(trig_w), .step(step_w), .page(page_q),
      .src_addr(rd_addr), .dst_addr(oam_addr), .last(last_w)
   );

   spd_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst(rst), .trig(trig_w), .last(last_w), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_req(rd_req), .oam_we(oam_we), .oam_wdata(oam_wdata),
      .step(step_w), .busy(busy), .done(done)
   );
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
   parameter int DATA_W   = 8,
   parameter int SYS_AW   = 16,
   parameter int PAGE_W   = 8,
   parameter int OAM_AW   = 8,
   parameter int OAM_BASE = 0
) (
   input logic              clk,
   input logic              rst,
   input logic              trig,
   input logic              rd_req,
   input logic [SYS_AW-1:0] rd_addr,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              oam_we,
   input logic [OAM_AW-1:0] oam_addr,
   input logic [DATA_W-1:0] oam_wdata,
   input logic              busy,
   input logic              done
);
   // R2 / R8: every trigger begins reading at offset zero
   assert_start_offset_R2: assert property (@(posedge clk) disable iff (rst)
      trig |=> (rd_req && rd_addr[PAGE_W-1:0] == '0));

   // R4: destination follows the source offset
   assert_dst_tracks_src_R4: assert property (@(posedge clk) disable iff (rst)
      oam_we |-> (oam_addr == OAM_AW'(OAM_BASE) + OAM_AW'(rd_addr[PAGE_W-1:0])));

   // R5: accepted read data is the next write data
   assert_data_copy_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_req && rd_valid && !trig) |=> (oam_we && oam_wdata == $past(rd_data)));

   // R6: one write per step, and nothing moves while idle
   assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
      (oam_we && !trig) |=> !oam_we);
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!rd_req && !oam_we));

   // R7: busy follows a trigger; done is a lone pulse with busy low
   assert_busy_after_trig_R7: assert property (@(posedge clk) disable iff (rst)
      trig |=> busy);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

bind sprite_page_dma spd_checker #(
   .DATA_W(DATA_W), .SYS_AW(SYS_AW), .PAGE_W(PAGE_W), .OAM_AW(OAM_AW), .OAM_BASE(OAM_BASE)
) u_chk (
   .clk(clk), .rst(rst), .trig(trig_w), .rd_req(rd_req), .rd_addr(rd_addr),
   .rd_valid(rd_valid), .rd_data(rd_data), .oam_we(oam_we), .oam_addr(oam_addr),
   .oam_wdata(oam_wdata), .busy(busy), .done(done)
);

// File: tb/sim_sprite_page_dma.sv
module sim_sprite_page_dma;
   localparam int COUNT = 160;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] cpu_addr = 4'd0;
   logic       cpu_wr = 1'b0;
   logic [7:0] cpu_wdata = 8'd0;
   logic [7:0] cpu_rdata;
   logic       rd_req;
   logic [15:0] rd_addr;
   logic       rd_valid;
   logic [7:0] rd_data = 8'd0;
   logic       oam_we;
   logic [7:0] oam_addr;
   logic [7:0] oam_wdata;
   logic       busy;
   logic       done;

   logic resp_valid = 1'b0;
   logic poke = 1'b0;
   assign rd_valid = resp_valid | poke;

   always #2.5 clk = ~clk;

   sprite_page_dma u0 (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
      .rd_data(rd_data), .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata),
      .busy(busy), .done(done)
   );

   int tests = 0;
   int fails = 0;
   int lat_mode = 0;
   int exp_off = 0;
   int nwrites = 0;
   int ndone = 0;
   int addr_err = 0;
   int data_err = 0;
   int wcnt = 0;
   logic [7:0] cur_page = 8'd0;

   function automatic logic [7:0] src_byte(input logic [15:0] a);
      return a[7:0] ^ (a[15:8] * 8'd37) ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor and read responder, evaluated mid-cycle
   always @(negedge clk) begin
      if (rst) begin
         resp_valid = 1'b0;
         wcnt = 0;
      end else begin
         if (oam_we) begin
            if (oam_addr != 8'(exp_off)) addr_err++;
            if (oam_wdata != src_byte({cur_page, 8'(exp_off)})) data_err++;
            exp_off++;
            nwrites++;
         end
         if (rd_req && rd_addr != {cur_page, 8'(exp_off)}) addr_err++;
         if (done) begin
            ndone++;
            if (busy) data_err++;
         end
         if (rd_req) begin
            int dly;
            dly = (lat_mode == 0) ? 0 : (exp_off % (lat_mode + 1)) + ((lat_mode == 3) ? 2 : 0);
            if (wcnt >= dly) begin
               resp_valid = 1'b1;
               rd_data = src_byte(rd_addr);
               wcnt = 0;
            end else begin
               resp_valid = 1'b0;
               wcnt++;
            end
         end else begin
            resp_valid = 1'b0;
            wcnt = 0;
         end
      end
   end

   // called at negedge + 1
   task automatic trigger(input logic [7:0] pg);
      cpu_addr = 4'd6; cpu_wdata = pg; cpu_wr = 1'b1;
      cur_page = pg; exp_off = 0; nwrites = 0;
      @(negedge clk); #1;
      cpu_wr = 1'b0;
      check(busy == 1'b1, "R7 busy after trigger", busy, 1);
      check(rd_addr == {pg, 8'h00}, "R2 first source address", rd_addr, {pg, 8'h00});
   endtask

   task automatic wait_done();
      int guard = 0;
      int seen = ndone;
      while (ndone == seen && guard < 4000) begin
         @(negedge clk); #1;
         guard++;
      end
      @(negedge clk); #1;
      check(done == 1'b0 && busy == 1'b0, "R7 done lasts one cycle", done, 0);
   endtask

   task automatic run_page(input logic [7:0] pg, input int lat);
      lat_mode = lat; ndone = 0; addr_err = 0; data_err = 0;
      trigger(pg);
      check(cpu_rdata == pg, "R1 readback", cpu_rdata, pg);
      wait_done();
      check(nwrites == COUNT, "R3 write count", nwrites, COUNT);
      check(addr_err == 0, "R4 address sequence", addr_err, 0);
      check(data_err == 0, "R5 copied data", data_err, 0);
      check(ndone == 1, "R7 one done pulse", ndone, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(busy == 0 && done == 0, "R9 reset busy/done", busy, 0);
      check(rd_req == 0 && oam_we == 0, "R9 reset quiet", rd_req, 0);
      cpu_addr = 4'd6;
      check(cpu_rdata == 8'h00, "R9 reset trigger register", cpu_rdata, 0);
      rst = 1'b0;
      @(negedge clk); #1;

      // R6: rd_valid while idle has no effect
      poke = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      poke = 1'b0;
      check(busy == 0 && nwrites == 0, "R6 stray rd_valid ignored", nwrites, 0);

      // sweep of pages and latencies (R2 R3 R4 R5 R6 R7)
      for (int i = 0; i < 6; i++) begin
         logic [7:0] pgs [6];
         pgs = '{8'h00, 8'h01, 8'h7F, 8'hFF, 8'hA5, 8'hC0};
         run_page(pgs[i], i % 4);
      end

      // R1: other address reads zero, trigger address keeps last value
      cpu_addr = 4'd5; #1;
      check(cpu_rdata == 8'h00, "R1 other address reads zero", cpu_rdata, 0);
      cpu_addr = 4'd6; #1;
      check(cpu_rdata == 8'hC0, "R1 value kept after copy", cpu_rdata, 8'hC0);

      // R8: retrigger mid-copy
      lat_mode = 2; ndone = 0; addr_err = 0; data_err = 0;
      trigger(8'h12);
      while (nwrites < 50) begin @(negedge clk); #1; end
      trigger(8'h34);
      wait_done();
      check(nwrites == COUNT, "R8 restart count", nwrites, COUNT);
      check(addr_err == 0 && data_err == 0, "R8 restart uses new page", addr_err + data_err, 0);
      check(ndone == 1, "R8 abandoned copy gives no done", ndone, 1);

      // R8: retrigger in the cycle of the final write
      lat_mode = 1; ndone = 0; addr_err = 0; data_err = 0;
      trigger(8'h56);
      while (nwrites < COUNT) begin @(negedge clk); #1; end
      check(oam_we == 1'b1, "R8 final write cycle reached", oam_we, 1);
      trigger(8'h78);
      check(ndone == 0 && done == 0, "R8 no done on final-cycle restart", ndone, 0);
      wait_done();
      check(nwrites == COUNT && ndone == 1, "R8 full copy after late restart", nwrites, COUNT);
      check(addr_err == 0 && data_err == 0, "R8 late restart data", addr_err + data_err, 0);

      // R9: reset during a copy
      lat_mode = 0; ndone = 0;
      trigger(8'h9A);
      while (nwrites < 30) begin @(negedge clk); #1; end
      rst = 1'b1;
      @(negedge clk); #1;
      check(busy == 0 && done == 0 && rd_req == 0 && oam_we == 0, "R9 reset mid-copy", busy, 0);
      check(cpu_rdata == 8'h00, "R9 trigger register cleared", cpu_rdata, 0);
      rst = 1'b0;
      nwrites = 0;
      repeat (5) @(negedge clk);
      #1;
      check(nwrites == 0 && busy == 0 && ndone == 0, "R9 no writes after reset", nwrites, 0);
      run_page(8'h3C, 3);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule